// File: doc/BRIEF.md
# Complement-Duplicate Checked Instruction Memory

This block is a read-only instruction store with error detection and self-repair. The store holds two copies, called pairs. Each pair has a primary memory and a companion memory that keeps the bitwise inverse of every primary word. On every fetch, each pair checks its own word against the inverse of its companion's word. The instruction is taken from pair 0 when pair 0's check passes, and from pair 1 when it does not. When both pairs fail at the same address, an error flag is raised.

A failed check in exactly one pair starts a repair. The repair walks every address in order and copies the healthy pair's primary words into the failing pair. The failing pair's primary receives each word as read, and its companion receives the inverse of that word. All repair traffic uses a second port on each memory, so fetches continue while the repair runs. The repair address advances once every two clock cycles: one cycle reads the source word, and the next cycle writes it to the failing pair.

The contents are computed rather than loaded. In the verification configuration, a parameter places a chosen bit flip into the starting contents of any of the four memories, so that each kind of upset can be studied.

Top module: `cdm_imem`

## Requirements
- R1: With no fault configured, the primary word at address a is (a*37 + 5) mod 2^DW, and the companion word at address a is the bitwise inverse of that value.
- R2: `instr` and `err` reflect the address presented at a rising clock edge and are valid after that edge, one cycle of latency. While reset is held and after it is released with a clean store, `busy` and `err` are 0.
- R3: A pair fails its check when its primary word is not the exact bitwise inverse of its companion word at the fetched address. Any single flipped bit is caught, and so is any run of adjacent bits flipped in the same word.
- R4: `instr` equals pair 0's primary word when pair 0 passes, and pair 1's primary word otherwise. A fault confined to one pair therefore never reaches `instr`.
- R5: When both pairs fail at the fetched address, `err` is 1 and `instr` carries pair 1's primary word. No repair starts.
- R6: When exactly one pair fails while no repair is active, `busy` rises on the next clock edge. It then stays high for exactly 2*2^AW cycles, because the repair address advances every second cycle.
- R7: A repair writes every address of the failing pair. Its primary receives the healthy pair's primary word, and its companion receives the inverse of that word. Afterwards, fetching the formerly bad address starts no new repair, and every address returns its R1 value.
- R8: Check failures seen while `busy` is 1 are ignored. Repeated fetches of a bad address during a repair neither restart nor lengthen it.
- R9: A word and its companion flipped in the same bit position pass the check. `instr` then shows the flipped word, `err` stays 0 and no repair starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for fetch, check and repair |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_addr | input | AW | Instruction fetch address |
| instr | output | DW | Fetched instruction, one cycle after the address |
| err | output | 1 | Both pairs failed their check at the fetched address |
| busy | output | 1 | A whole-memory repair is in progress |

## Verification
The assertions check the following on every cycle:
- the repair starts after a single-pair failure and does not start after a double failure;
- write enables appear only during a repair, in at most one pair, and never on two consecutive cycles;
- each repair lasts exactly twice the depth.

Only the bench scenarios can show what ends up in memory. These scenarios show that the repaired pair holds correct contents, because a refetch of the bad address stays quiet and a later sweep still matches. They also show which word `instr` carries under each fault pattern, and that a same-position flip in a word and its companion passes undetected.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
  typedef enum logic {SCR_IDLE, SCR_COPY} scr_st_e;

  localparam int IMG_MUL = 37;
  localparam int IMG_ADD = 5;
endpackage

// File: rtl/cdm_bank.sv
module cdm_bank
  import cdm_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter bit INV = 1'b0,
  parameter logic [AW-1:0] FLT_ADDR = '0,
  parameter logic [DW-1:0] FLT_MASK = '0
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Starting image: computed word, inverted for a companion, optional flip.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] tmp;
      logic [DW-1:0] w;
      tmp = i * IMG_MUL + IMG_ADD;
      w = tmp[DW-1:0];
      if (INV) w = ~w;
      if (i == int'(FLT_ADDR)) w = w ^ FLT_MASK;
      mem[i] = w;
    end
  end

  // Port A: fetch read. Port B: repair read and write, read returns old data.
  always_ff @(posedge clk) begin
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
    if (b_we) mem[b_addr] <= b_wdata;
  end
endmodule

// File: rtl/cdm_pair.sv
module cdm_pair #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [2*AW-1:0] FLT_ADDR = '0,
  parameter logic [2*DW-1:0] FLT_MASK = '0
) (
  input  logic          clk,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] scr_addr,
  input  logic          scr_we,
  input  logic [DW-1:0] scr_wdata,
  output logic [DW-1:0] word,
  output logic          fail,
  output logic [DW-1:0] scr_rdata
);
  logic [1:0][DW-1:0] a_rd;
  logic [1:0][DW-1:0] b_rd;
  logic unused_cmp_rd;

  // Bank 0 is the primary, bank 1 the companion holding inverted words.
  for (genvar g = 0; g < 2; g++) begin : g_bank
    cdm_bank #(
      .AW(AW),
      .DW(DW),
      .INV(g == 1),
      .FLT_ADDR(FLT_ADDR[g*AW +: AW]),
      .FLT_MASK(FLT_MASK[g*DW +: DW])
    ) u_bank (
      .clk(clk),
      .a_addr(fetch_addr),
      .a_rdata(a_rd[g]),
      .b_addr(scr_addr),
      .b_we(scr_we),
      .b_wdata((g == 1) ? ~scr_wdata : scr_wdata),
      .b_rdata(b_rd[g])
    );
  end

  always_comb begin
    word = a_rd[0];
    fail = (a_rd[0] != ~a_rd[1]);
    scr_rdata = b_rd[0];
  end

  assign unused_cmp_rd = ^b_rd[1];
endmodule

// File: rtl/cdm_scrub.sv
module cdm_scrub
  import cdm_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fail,
  output logic          busy,
  output logic          dst,
  output logic [AW-1:0] scr_addr,
  output logic [1:0]    we
);
  localparam logic [AW-1:0] LAST = '1;

  scr_st_e       st_q, st_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          dst_q, dst_d;
  logic          adv, start, cnt_en;

  // Next state: start on a single-pair failure, walk addresses at half rate.
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ph_d  = ph_q;
    dst_d = dst_q;
    adv   = (st_q == SCR_COPY) && ph_q;
    start = (st_q == SCR_IDLE) && (fail == 2'b01 || fail == 2'b10);
    unique case (st_q)
      SCR_IDLE: begin
        if (start) begin
          st_d  = SCR_COPY;
          dst_d = fail[1];
          cnt_d = '0;
          ph_d  = 1'b0;
        end
      end
      SCR_COPY: begin
        ph_d = ~ph_q;
        if (adv) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) st_d = SCR_IDLE;
        end
      end
      default: st_d = SCR_IDLE;
    endcase
    cnt_en = start || adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SCR_IDLE;
      cnt_q <= '0;
      ph_q  <= 1'b0;
      dst_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
      if (start) dst_q <= dst_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  always_comb begin
    busy     = (st_q == SCR_COPY);
    dst      = dst_q;
    scr_addr = cnt_q;
    we       = 2'b00;
    if (busy && ph_q) we[dst_q] = 1'b1;
  end
endmodule

// File: rtl/cdm_imem.sv
module cdm_imem
  import cdm_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [4*AW-1:0] FLT_ADDR = '0,
  parameter logic [4*DW-1:0] FLT_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetch_addr,
  output logic [DW-1:0] instr,
  output logic          err,
  output logic          busy
);
  logic          rst_meta_n, rst_q_n;
  logic [1:0][DW-1:0] word, scr_rd;
  logic [1:0]    fail, scr_we;
  logic [AW-1:0] scr_addr;
  logic          dst;
  logic [DW-1:0] scr_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_pair
    cdm_pair #(
      .AW(AW),
      .DW(DW),
      .FLT_ADDR(FLT_ADDR[p*2*AW +: 2*AW]),
      .FLT_MASK(FLT_MASK[p*2*DW +: 2*DW])
    ) u_pair (
      .clk(clk),
      .fetch_addr(fetch_addr),
      .scr_addr(scr_addr),
      .scr_we(scr_we[p]),
      .scr_wdata(scr_wdata),
      .word(word[p]),
      .fail(fail[p]),
      .scr_rdata(scr_rd[p])
    );
  end

  cdm_scrub #(.AW(AW)) u_scrub (
    .clk(clk),
    .rst_n(rst_q_n),
    .fail(fail),
    .busy(busy),
    .dst(dst),
    .scr_addr(scr_addr),
    .we(scr_we)
  );

  always_comb begin
    scr_wdata = dst ? scr_rd[0] : scr_rd[1];
    instr     = fail[0] ? word[1] : word[0];
    err       = fail[0] && fail[1];
  end
endmodule

// File: rtl/cdm_imem_chk.sv
module cdm_imem_chk #(
  parameter int AW = 4
) (
  input logic       clk,
  input logic       rst_q_n,
  input logic [1:0] fail,
  input logic       busy,
  input logic [1:0] we
);
  localparam int RUN = 2 * (1 << AW);

  int run_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else run_q <= 0;
  end

  assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy && (fail == 2'b01 || fail == 2'b10)) |=> busy);

  assert_no_start_double_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy && fail == 2'b11) |=> !busy);

  assert_we_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|we) |-> (busy && $onehot0(we)));

  assert_we_half_rate_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|we) |=> !(|we));

  assert_run_length_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy && $past(busy)) |-> (run_q == RUN));

  assert_run_bound_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    busy |-> (run_q < RUN));
endmodule

bind cdm_imem cdm_imem_chk #(.AW(AW)) u_chk (
  .clk(clk),
  .rst_q_n(rst_q_n),
  .fail(fail),
  .busy(busy),
  .we(scr_we)
);

// File: tb/tb_cdm_imem.sv
module tb_cdm_imem;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [4*AW-1:0] FA = 16'h5555;
  localparam int BAD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] ins [5];
  logic [4:0] er, bsy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cur [5];
  int runs [5];
  int last [5];

  always #2 clk = ~clk;

  // 0 clean, 1 single bit in pair0 primary, 2 adjacent bits in pair1 companion,
  // 3 both primaries flipped, 4 same bit in pair0 primary and companion
  cdm_imem #(.AW(AW), .DW(DW), .FLT_ADDR(FA), .FLT_MASK(32'h0)) dut (
    .clk(clk), .rst_n(rst_n), .fetch_addr(addr), .instr(ins[0]), .err(er[0]), .busy(bsy[0]));
  cdm_imem #(.AW(AW), .DW(DW), .FLT_ADDR(FA), .FLT_MASK(32'h0000_0001)) dut_f0 (
    .clk(clk), .rst_n(rst_n), .fetch_addr(addr), .instr(ins[1]), .err(er[1]), .busy(bsy[1]));
  cdm_imem #(.AW(AW), .DW(DW), .FLT_ADDR(FA), .FLT_MASK(32'h1800_0000)) dut_f1 (
    .clk(clk), .rst_n(rst_n), .fetch_addr(addr), .instr(ins[2]), .err(er[2]), .busy(bsy[2]));
  cdm_imem #(.AW(AW), .DW(DW), .FLT_ADDR(FA), .FLT_MASK(32'h0040_0004)) dut_ff (
    .clk(clk), .rst_n(rst_n), .fetch_addr(addr), .instr(ins[3]), .err(er[3]), .busy(bsy[3]));
  cdm_imem #(.AW(AW), .DW(DW), .FLT_ADDR(FA), .FLT_MASK(32'h0000_0202)) dut_un (
    .clk(clk), .rst_n(rst_n), .fetch_addr(addr), .instr(ins[4]), .err(er[4]), .busy(bsy[4]));

  function automatic logic [DW-1:0] img(input int a);
    int t;
    t = (a * 37 + 5) % (1 << DW);
    return t[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] exp_ins(input int d, input int a);
    if (a == BAD && d == 3) return img(a) ^ 8'h40;
    if (a == BAD && d == 4) return img(a) ^ 8'h02;
    return img(a);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Measure every busy run on each instance.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 5; i++) begin
        if (bsy[i]) cur[i]++;
        else if (cur[i] != 0) begin
          runs[i]++;
          last[i] = cur[i];
          cur[i] = 0;
        end
      end
    end
  end

  task automatic sweep(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      addr = a[AW-1:0];
      @(negedge clk);
      chk({tag, " R1 R2 clean word"}, ins[0], img(a));
      chk({tag, " R2 clean err"}, er[0], 0);
      chk({tag, " R4 R3 pair0 single-bit fault hidden"}, ins[1], exp_ins(1, a));
      chk({tag, " R4 R3 pair1 adjacent fault hidden"}, ins[2], exp_ins(2, a));
      chk({tag, " R5 both-fail word from pair1"}, ins[3], exp_ins(3, a));
      chk({tag, " R5 both-fail err"}, er[3], (a == BAD) ? 1 : 0);
      chk({tag, " R9 same-bit flip undetected"}, ins[4], exp_ins(4, a));
      chk({tag, " R9 err low"}, er[4], 0);
      if (tag == "first" && a == BAD) begin
        chk("R6 busy not yet high in result cycle", bsy[1], 0);
      end
      if (tag == "first" && a == BAD + 1) begin
        chk("R6 busy high one edge after failure", bsy[1], 1);
        chk("R6 busy high one edge after failure pair1", bsy[2], 1);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin
      cur[i] = 0;
      runs[i] = 0;
      last[i] = 0;
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      chk("R2 busy low in reset", bsy[i], 0);
      chk("R2 err low in reset", er[i], 0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 busy low after reset", bsy[0], 0);

    sweep("first");

    // Hold the bad address through and past the repair.
    addr = BAD[AW-1:0];
    for (int c = 0; c < 48; c++) begin
      @(negedge clk);
      chk("R4 R8 pair0-fault instr during hold", ins[1], img(BAD));
      chk("R4 R8 pair1-fault instr during hold", ins[2], img(BAD));
      chk("R5 double failure never repairs", bsy[3], 0);
      chk("R5 double failure err held", er[3], 1);
      chk("R9 undetected flip never repairs", bsy[4], 0);
    end

    chk("R7 pair0 repair finished", bsy[1], 0);
    chk("R7 pair1 repair finished", bsy[2], 0);

    sweep("second");

    chk("R3 clean store never repairs", runs[0], 0);
    chk("R7 R8 pair0 fault repaired once", runs[1], 1);
    chk("R6 pair0 repair length", last[1], 2 * DEPTH);
    chk("R7 R8 pair1 fault repaired once", runs[2], 1);
    chk("R6 pair1 repair length", last[2], 2 * DEPTH);
    chk("R5 no repair on double failure", runs[3], 0);
    chk("R9 no repair on undetected flip", runs[4], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule